// File: doc/BRIEF.md
# Controller Status Byte with Wake-Cause Flags

This block keeps the eight-bit status byte of a small controller core. It stores a free storage bit, a two-bit page preselect that feeds the upper bits of the program counter, the three arithmetic flags produced by the ALU, and two flags that record why the core last woke or reset: a time-out flag and a power-down flag.

Software writes, ALU flag updates, sleep and watchdog-clear instruction strobes, and a watchdog expiry pulse all arrive on their own inputs. The block resolves them into the next byte at each clock edge. It presents the whole byte for reads and the page preselect bits for the program counter. The time-out and power-down flags change only on power-on reset and on the three event strobes. A reset handler can read them to tell power-on, watchdog expiry during run, and watchdog expiry during sleep apart.

Top module: `ctl_status`

## Requirements
- R1: A clock edge with `rst_n` low loads the byte 0x18. Bit 4 (time-out) and bit 3 (power-down) become 1. Bit 7, bits 6:5 and bits 2:0 become 0.
- R2: A software write (`sw_we`=1) loads `sw_wdata` bits 7:5 and 2:0 into the same byte positions. Bits 4:3 of the byte are not changed by the write.
- R3: `page_sel` always shows byte bits 6:5. Bit 6 is the high page bit.
- R4: `alu_flag_we` is a per-flag mask: bit 2 for zero, bit 1 for digit carry, bit 0 for carry. A masked-in zero flag becomes 1 when `alu_result` is all zeros and 0 otherwise. A masked-in digit carry or carry takes `alu_dc` or `alu_c`. Masked-out flags keep their value.
- R5: When a software write and an ALU update occur in the same cycle, bits 2:0 take the software value.
- R6: `sleep_cmd` alone sets the time-out flag to 1 and clears the power-down flag to 0.
- R7: `wdt_clr_cmd` alone sets both the time-out flag and the power-down flag to 1.
- R8: `wdt_timeout` clears the time-out flag to 0, even when `sleep_cmd` or `wdt_clr_cmd` is high in the same cycle.
- R9: When `sleep_cmd` and `wdt_clr_cmd` are both high, the power-down flag becomes 0 and the time-out flag becomes 1, unless R8 applies.
- R10: `wdt_timeout` alone leaves the power-down flag unchanged.
- R11: All updates show on `status_rd` after the clock edge that samples them. Without any event, the byte holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 8 | Software write data |
| alu_flag_we | input | 3 | Flag update mask: {zero, digit carry, carry} |
| alu_result | input | DATA_W | ALU result, used for the zero flag |
| alu_dc | input | 1 | Digit carry from the ALU |
| alu_c | input | 1 | Carry from the ALU |
| sleep_cmd | input | 1 | Sleep instruction strobe |
| wdt_clr_cmd | input | 1 | Watchdog-clear instruction strobe |
| wdt_timeout | input | 1 | Watchdog expiry pulse |
| status_rd | output | 8 | Current status byte |
| page_sel | output | 2 | Page preselect to the program counter |

## Verification
Two pairs of functions can fall in the same cycle. A software write can meet an ALU flag update on the low flag bits. A watchdog expiry can meet a sleep or watchdog-clear strobe on the time-out flag. Directed cycles force each pair together with known values and check the byte for the winner of R5, R8 and R9. Random cycles then raise all strobes at once with adjustable density, and each cycle's byte is compared with a bench model built from the requirements.

// File: rtl/ctl_status_pkg.sv
// Shared bit positions, reset value and packed view of the status byte.
package ctl_status_pkg;
    localparam int STAT_W   = 8;
    localparam int PAGE_W   = 2;
    localparam int ARITH_W  = 3;
    localparam int GP_POS   = 7;
    localparam int PS_LO    = 5;
    localparam int TO_POS   = 4;
    localparam int PD_POS   = 3;
    localparam int ZF_POS   = 2;
    localparam logic [STAT_W-1:0] STAT_RESET = 8'h18;

    typedef struct packed {
        logic              gp;
        logic [PAGE_W-1:0] page;
        logic              tof;
        logic              pdf;
        logic              zf;
        logic              dcf;
        logic              cf;
    } stat_t;
endpackage

// File: rtl/ctl_status_ctrl_bits.sv
// Holds the free storage bit and the page preselect bits.
// Assumes: these bits change only on software writes and reset.
module ctl_status_ctrl_bits
    import ctl_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic              wr_gp,
    input  logic [PAGE_W-1:0] wr_page,
    output logic              gp_q,
    output logic [PAGE_W-1:0] page_q
);
    // Load the storage and page bits from software, clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gp_q   <= 1'b0;
            page_q <= '0;
        end else if (sw_we) begin
            gp_q   <= wr_gp;
            page_q <= wr_page;
        end
    end
endmodule

// File: rtl/ctl_status_power_flags.sv
// Time-out and power-down flags, driven only by reset and the event strobes.
// Assumes: the strobes are single-cycle pulses. Expiry beats every set of the
// time-out flag. Sleep beats watchdog-clear on the power-down flag.
module ctl_status_power_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_cmd,
    input  logic wdt_clr_cmd,
    input  logic wdt_timeout,
    output logic tof_q,
    output logic pdf_q
);
    // Time-out flag: expiry clears it, sleep or clear sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tof_q <= 1'b1;
        else if (wdt_timeout)
            tof_q <= 1'b0;
        else if (sleep_cmd || wdt_clr_cmd)
            tof_q <= 1'b1;
    end

    // Power-down flag: sleep clears it, watchdog clear sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pdf_q <= 1'b1;
        else if (sleep_cmd)
            pdf_q <= 1'b0;
        else if (wdt_clr_cmd)
            pdf_q <= 1'b1;
    end
endmodule

// File: rtl/ctl_status_arith_flags.sv
// Zero, digit-carry and carry flags, each with its own update enable.
// Assumes: a software write has priority over the ALU on the same cycle.
module ctl_status_arith_flags
    import ctl_status_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_we,
    input  logic [ARITH_W-1:0] sw_flags,
    input  logic [ARITH_W-1:0] alu_we,
    input  logic [DATA_W-1:0]  alu_result,
    input  logic               alu_dc,
    input  logic               alu_c,
    output logic [ARITH_W-1:0] flags_q
);
    logic               res_zero;
    logic [ARITH_W-1:0] alu_val;

    // Detect an all-zero result and gather the ALU flag values.
    always_comb begin
        res_zero = ~|alu_result;
        alu_val  = {res_zero, alu_dc, alu_c};
    end

    // One register per flag: software first, then the ALU when enabled.
    for (genvar i = 0; i < ARITH_W; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags_q[i] <= 1'b0;
            else if (sw_we)
                flags_q[i] <= sw_flags[i];
            else if (alu_we[i])
                flags_q[i] <= alu_val[i];
        end
    end
endmodule

// File: rtl/ctl_status.sv
// Status byte top. Joins the storage/page bits, the power flags and the
// arithmetic flags into one readable byte and drives the page preselect.
// Assumes: synchronous active-low reset acts as power-on reset.
module ctl_status
    import ctl_status_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_we,
    input  logic [STAT_W-1:0]  sw_wdata,
    input  logic [ARITH_W-1:0] alu_flag_we,
    input  logic [DATA_W-1:0]  alu_result,
    input  logic               alu_dc,
    input  logic               alu_c,
    input  logic               sleep_cmd,
    input  logic               wdt_clr_cmd,
    input  logic               wdt_timeout,
    output logic [STAT_W-1:0]  status_rd,
    output logic [PAGE_W-1:0]  page_sel
);
    stat_t              wr_view;
    stat_t              cur;
    logic               gp_q;
    logic [PAGE_W-1:0]  page_q;
    logic               tof_q;
    logic               pdf_q;
    logic [ARITH_W-1:0] flags_q;

    // Split the write data into named fields.
    always_comb wr_view = stat_t'(sw_wdata);

    ctl_status_ctrl_bits u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_we   (sw_we),
        .wr_gp   (wr_view.gp),
        .wr_page (wr_view.page),
        .gp_q    (gp_q),
        .page_q  (page_q)
    );

    ctl_status_power_flags u_pwr (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_cmd   (sleep_cmd),
        .wdt_clr_cmd (wdt_clr_cmd),
        .wdt_timeout (wdt_timeout),
        .tof_q       (tof_q),
        .pdf_q       (pdf_q)
    );

    ctl_status_arith_flags #(.DATA_W(DATA_W)) u_arith (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_we      (sw_we),
        .sw_flags   ({wr_view.zf, wr_view.dcf, wr_view.cf}),
        .alu_we     (alu_flag_we),
        .alu_result (alu_result),
        .alu_dc     (alu_dc),
        .alu_c      (alu_c),
        .flags_q    (flags_q)
    );

    // Assemble the readable byte and the page output.
    always_comb begin
        cur.gp   = gp_q;
        cur.page = page_q;
        cur.tof  = tof_q;
        cur.pdf  = pdf_q;
        cur.zf   = flags_q[2];
        cur.dcf  = flags_q[1];
        cur.cf   = flags_q[0];
        status_rd = cur;
        page_sel  = cur.page;
    end
endmodule

// File: rtl/ctl_status_chk.sv
// Property checker for ctl_status, bound into every instance.
module ctl_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sw_we,
    input logic [7:0] sw_wdata,
    input logic [2:0] alu_flag_we,
    input logic       sleep_cmd,
    input logic       wdt_clr_cmd,
    input logic       wdt_timeout,
    input logic [7:0] status_rd
);
    logic was_rst = 1'b0;

    // Remember whether the previous edge applied reset.
    always_ff @(posedge clk) was_rst <= !rst_n;

    // R1: the byte after a reset edge is the reset value.
    always_ff @(posedge clk) begin
        if (was_rst && rst_n)
            a_r1_reset_value: assert (status_rd == 8'h18);
    end

    // R2: a write with no event keeps bits 4:3.
    a_r2_write_keeps_power: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && !sleep_cmd && !wdt_clr_cmd && !wdt_timeout)
        |=> status_rd[4:3] == $past(status_rd[4:3]));

    // R5: the write value lands in the writable bits, whatever the ALU does.
    a_r5_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> {status_rd[7:5], status_rd[2:0]} == $past({sw_wdata[7:5], sw_wdata[2:0]}));

    // R4: with no write and no mask, the arithmetic flags hold.
    a_r4_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && alu_flag_we == 3'b000) |=> $stable(status_rd[2:0]));

    // R6: sleep alone gives time-out 1 and power-down 0.
    a_r6_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_cmd && !wdt_timeout) |=> status_rd[4:3] == 2'b10);

    // R7: watchdog clear alone sets both power flags.
    a_r7_wdt_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_clr_cmd && !sleep_cmd && !wdt_timeout) |=> status_rd[4:3] == 2'b11);

    // R8: expiry always clears the time-out flag.
    a_r8_timeout_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_timeout |=> !status_rd[4]);
endmodule

bind ctl_status ctl_status_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_we       (sw_we),
    .sw_wdata    (sw_wdata),
    .alu_flag_we (alu_flag_we),
    .sleep_cmd   (sleep_cmd),
    .wdt_clr_cmd (wdt_clr_cmd),
    .wdt_timeout (wdt_timeout),
    .status_rd   (status_rd)
);

// File: tb/ctl_status_bench.sv
module ctl_status_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_we = 1'b0;
    logic [7:0] sw_wdata = '0;
    logic [2:0] alu_flag_we = '0;
    logic [7:0] alu_result = '0;
    logic       alu_dc = 1'b0;
    logic       alu_c = 1'b0;
    logic       sleep_cmd = 1'b0;
    logic       wdt_clr_cmd = 1'b0;
    logic       wdt_timeout = 1'b0;
    logic [7:0] status_rd;
    logic [1:0] page_sel;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_st;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ctl_status u_ctl_status (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .alu_flag_we(alu_flag_we), .alu_result(alu_result), .alu_dc(alu_dc),
        .alu_c(alu_c), .sleep_cmd(sleep_cmd), .wdt_clr_cmd(wdt_clr_cmd),
        .wdt_timeout(wdt_timeout), .status_rd(status_rd), .page_sel(page_sel)
    );

    // Next byte from the requirements.
    function automatic logic [7:0] model(input logic [7:0] cur);
        logic [7:0] n = cur;
        if (!rst_n) return 8'h18;
        if (alu_flag_we[2]) n[2] = (alu_result == 8'h00);
        if (alu_flag_we[1]) n[1] = alu_dc;
        if (alu_flag_we[0]) n[0] = alu_c;
        if (sw_we) begin
            n[7:5] = sw_wdata[7:5];
            n[2:0] = sw_wdata[2:0];
        end
        if (wdt_timeout) n[4] = 1'b0;
        else if (sleep_cmd || wdt_clr_cmd) n[4] = 1'b1;
        if (sleep_cmd) n[3] = 1'b0;
        else if (wdt_clr_cmd) n[3] = 1'b1;
        return n;
    endfunction

    task automatic check(input string tag);
        total++;
        if (status_rd !== exp_st) begin
            bad++;
            $display("FAIL %s status actual=%h expected=%h", tag, status_rd, exp_st);
        end
        total++;
        if (page_sel !== exp_st[6:5]) begin
            bad++;
            $display("FAIL R3 (%s) page_sel actual=%b expected=%b", tag, page_sel, exp_st[6:5]);
        end
    endtask

    task automatic idle();
        sw_we = 0; alu_flag_we = 0; sleep_cmd = 0; wdt_clr_cmd = 0; wdt_timeout = 0;
    endtask

    // One cycle: inputs set at a falling edge, result checked at the next.
    task automatic step(input string tag);
        exp_st = model(exp_st);
        @(negedge clk);
        check(tag);
        idle();
    endtask

    initial begin
        void'($urandom(32'd4242));
        exp_st = 8'h00;
        @(negedge clk);
        rst_n = 0; step("R1 reset");
        rst_n = 1;
        step("R11 hold");
        sw_we = 1; sw_wdata = 8'h00; step("R2 write zero keeps power bits");
        sw_we = 1; sw_wdata = 8'hA5; step("R2 write A5");
        alu_flag_we = 3'b111; alu_result = 8'h00; alu_dc = 0; alu_c = 0; step("R4 zero result");
        alu_flag_we = 3'b100; alu_result = 8'h05; alu_dc = 1; alu_c = 1; step("R4 masked zero only");
        sw_we = 1; sw_wdata = 8'h42; alu_flag_we = 3'b111; alu_result = 8'h00;
        alu_dc = 1; alu_c = 1; step("R5 write beats ALU");
        sleep_cmd = 1; step("R6 sleep");
        wdt_timeout = 1; step("R10 timeout keeps power-down");
        wdt_clr_cmd = 1; step("R7 watchdog clear");
        wdt_timeout = 1; wdt_clr_cmd = 1; step("R8 timeout beats clear");
        sleep_cmd = 1; wdt_clr_cmd = 1; step("R9 sleep with clear");
        wdt_timeout = 1; sleep_cmd = 1; step("R8 timeout beats sleep");
        sw_we = 1; sw_wdata = 8'h18; step("R2 write cannot set power bits");
        for (int i = 0; i < 600; i++) begin
            rst_n       = ($urandom % 64) != 0;
            sw_we       = ($urandom % 4) == 0;
            sw_wdata    = 8'($urandom);
            alu_flag_we = 3'($urandom);
            alu_result  = ($urandom % 3 == 0) ? 8'h00 : 8'($urandom);
            alu_dc      = 1'($urandom);
            alu_c       = 1'($urandom);
            sleep_cmd   = ($urandom % 6) == 0;
            wdt_clr_cmd = ($urandom % 6) == 0;
            wdt_timeout = ($urandom % 6) == 0;
            step("R4/R5/R8/R9 random");
        end
        rst_n = 1;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 5000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R11 watchdog expired actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule